// File: doc/BRIEF.md
# Segment Address Translation Unit

This block turns a virtual address into a physical address through a segment table private to one process. The high field of the virtual address names a segment, and the low field is an offset within it. The unit keeps a table-origin register and a table-length register, which software loads together. Table entries live in a small internal array that software fills through a write port. Each entry holds a valid flag, a physical base, a bound (the segment length) and three permission flags.

A request carries the virtual address and an access kind. One cycle later a response strobe returns either the translated address or a fault code. Translation walks four checks in a fixed order: range, valid, bound and permission. Only the first check that fails is reported. When every check passes, the physical address is the entry's base plus the offset.

Top module: `seg_xlate`

## Requirements
- R1: The segment number is virtual address bits [SEG_W+OFF_W-1:OFF_W] and the offset is bits [OFF_W-1:0]. With the defaults, bits [15:12] are the segment and bits [11:0] are the offset.
- R2: A segment number greater than or equal to the table-length register gives fault code 1.
- R3: An entry whose valid flag is clear gives fault code 2.
- R4: An offset greater than or equal to the entry's bound gives fault code 3.
- R5: The access kind is encoded as 0 for read, 1 for write, 2 for execute and 3 for reserved. Read needs permission bit 0, write needs bit 1 and execute needs bit 2. Code 3 is never allowed. A disallowed access gives fault code 4.
- R6: Checks are applied in the order range, valid, bound, permission, and only the first failing one is reported.
- R7: With no fault, the fault code is 0 and the address is base plus zero-extended offset, modulo 2^PA_W. On any fault the address output is 0.
- R8: The entry used is (origin register + segment number) modulo 2^SEG_W. A configuration write loads both the origin and the length registers.
- R9: The response strobe rises exactly one cycle after each request cycle, and it stays low after cycles without a request.
- R10: A table write in the same cycle as a request does not affect that request. It does affect the next request.
- R11: After reset the response strobe is low, both table registers are 0 and every entry is invalid, so any request gives fault code 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load origin and length registers |
| cfg_origin | input | SEG_W | Table origin value |
| cfg_length | input | SEG_W+1 | Table length value (number of segments) |
| tw_en | input | 1 | Table entry write enable |
| tw_idx | input | SEG_W | Entry index to write |
| tw_valid | input | 1 | Valid flag for the entry |
| tw_base | input | PA_W | Physical base for the entry |
| tw_bound | input | OFF_W+1 | Segment length for the entry |
| tw_perm | input | 3 | Permission flags {exec, write, read} |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | SEG_W+OFF_W | Virtual address |
| req_acc | input | 2 | Access kind |
| rsp_valid | output | 1 | Response strobe |
| rsp_fault | output | 3 | Fault code, 0 on success |
| rsp_paddr | output | PA_W | Physical address, 0 on fault |

## Verification
A vector table exercises the translation with several patterns. Offsets sit just below and exactly at the bound, which separates a strict from an inclusive comparison. Each access kind is tried against entries that allow only part of the set, which exposes a swapped permission bit. A base near the top of the address space shows wraparound in the sum. Addresses that fail two checks at once, such as out of range onto a valid entry or over the bound with a forbidden access, pin down the check order. Directed sequences cover the reset state, idle cycles, a table write that coincides with a request, and an origin value that wraps the entry index.

// File: rtl/seg_xlate.sv
module seg_xlate #(
  parameter int SEG_W = 4,
  parameter int OFF_W = 12,
  parameter int PA_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [SEG_W-1:0]   cfg_origin,
  input  logic [SEG_W:0]     cfg_length,
  input  logic               tw_en,
  input  logic [SEG_W-1:0]   tw_idx,
  input  logic               tw_valid,
  input  logic [PA_W-1:0]    tw_base,
  input  logic [OFF_W:0]     tw_bound,
  input  logic [2:0]         tw_perm,
  input  logic               req_valid,
  input  logic [SEG_W+OFF_W-1:0] req_vaddr,
  input  logic [1:0]         req_acc,
  output logic               rsp_valid,
  output logic [2:0]         rsp_fault,
  output logic [PA_W-1:0]    rsp_paddr
);
  localparam int DEPTH = 1 << SEG_W;
  localparam int VA_W  = SEG_W + OFF_W;
  localparam logic [2:0] F_OK = 3'd0, F_RANGE = 3'd1, F_INVALID = 3'd2,
                         F_BOUND = 3'd3, F_PERM = 3'd4;

  logic             ent_v     [DEPTH];
  logic [PA_W-1:0]  ent_base  [DEPTH];
  logic [OFF_W:0]   ent_bound [DEPTH];
  logic [2:0]       ent_perm  [DEPTH];

  logic [SEG_W-1:0] origin_q;
  logic [SEG_W:0]   length_q;

  logic [SEG_W-1:0] seg;
  logic [OFF_W-1:0] off;
  logic [SEG_W-1:0] idx;
  assign seg = req_vaddr[VA_W-1:OFF_W];
  assign off = req_vaddr[OFF_W-1:0];
  assign idx = origin_q + seg;

  logic in_range, off_ok, perm_ok;
  assign in_range = {1'b0, seg} < length_q;
  assign off_ok   = {1'b0, off} < ent_bound[idx];

  always_comb begin
    case (req_acc)
      2'd0:    perm_ok = ent_perm[idx][0];
      2'd1:    perm_ok = ent_perm[idx][1];
      2'd2:    perm_ok = ent_perm[idx][2];
      default: perm_ok = 1'b0;
    endcase
  end

  logic [2:0] fault_nx;
  always_comb begin
    if (!in_range)          fault_nx = F_RANGE;
    else if (!ent_v[idx])   fault_nx = F_INVALID;
    else if (!off_ok)       fault_nx = F_BOUND;
    else if (!perm_ok)      fault_nx = F_PERM;
    else                    fault_nx = F_OK;
  end

  logic [PA_W-1:0] sum;
  assign sum = ent_base[idx] + {{(PA_W-OFF_W){1'b0}}, off};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      origin_q <= '0;
      length_q <= '0;
    end else if (cfg_we) begin
      origin_q <= cfg_origin;
      length_q <= cfg_length;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ent_v[i] <= 1'b0;
    end else if (tw_en) begin
      ent_v[tw_idx] <= tw_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (tw_en) begin
      ent_base[tw_idx]  <= tw_base;
      ent_bound[tw_idx] <= tw_bound;
      ent_perm[tw_idx]  <= tw_perm;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_fault <= F_OK;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_fault <= fault_nx;
        rsp_paddr <= (fault_nx == F_OK) ? sum : '0;
      end
    end
  end

  a_r9_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  a_r6_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_fault <= F_PERM);
  a_r7_zero_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != F_OK) |-> rsp_paddr == '0);
  a_r2_range_first: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ({1'b0, req_vaddr[VA_W-1:OFF_W]} >= length_q)) |=> rsp_fault == F_RANGE);
  a_r8_cfg_load: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (length_q == $past(cfg_length)) && (origin_q == $past(cfg_origin)));
endmodule

// File: tb/sim_seg_xlate.sv
module sim_seg_xlate;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        cfg_we = 0;
  logic [3:0]  cfg_origin = 0;
  logic [4:0]  cfg_length = 0;
  logic        tw_en = 0;
  logic [3:0]  tw_idx = 0;
  logic        tw_valid = 0;
  logic [15:0] tw_base = 0;
  logic [12:0] tw_bound = 0;
  logic [2:0]  tw_perm = 0;
  logic        req_valid = 0;
  logic [15:0] req_vaddr = 0;
  logic [1:0]  req_acc = 0;
  logic        rsp_valid;
  logic [2:0]  rsp_fault;
  logic [15:0] rsp_paddr;

  seg_xlate u0 (.*);

  int checks = 0;
  int fails = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] i, input logic v, input logic [15:0] b,
                    input logic [12:0] bd, input logic [2:0] p);
    @(negedge clk);
    tw_en = 1; tw_idx = i; tw_valid = v; tw_base = b; tw_bound = bd; tw_perm = p;
    @(negedge clk);
    tw_en = 0;
  endtask

  task automatic cfg(input logic [3:0] o, input logic [4:0] l);
    @(negedge clk);
    cfg_we = 1; cfg_origin = o; cfg_length = l;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic xl(input logic [15:0] va, input logic [1:0] acc);
    @(negedge clk);
    req_valid = 1; req_vaddr = va; req_acc = acc;
    @(negedge clk);
    req_valid = 0;
  endtask

  // {vaddr, acc, fault, paddr}
  localparam int NV = 14;
  localparam logic [36:0] VEC [NV] = '{
    {16'h0010, 2'd0, 3'd0, 16'h1010},
    {16'h00FF, 2'd1, 3'd0, 16'h10FF},
    {16'h0100, 2'd0, 3'd3, 16'h0000},
    {16'h0010, 2'd2, 3'd4, 16'h0000},
    {16'h1000, 2'd0, 3'd2, 16'h0000},
    {16'h1FFF, 2'd3, 3'd2, 16'h0000},
    {16'h2005, 2'd2, 3'd0, 16'h8005},
    {16'h2005, 2'd1, 3'd4, 16'h0000},
    {16'h2800, 2'd1, 3'd3, 16'h0000},
    {16'h5200, 2'd0, 3'd0, 16'h0100},
    {16'h6000, 2'd0, 3'd1, 16'h0000},
    {16'hF000, 2'd0, 3'd1, 16'h0000},
    {16'h0010, 2'd3, 3'd4, 16'h0000},
    {16'h5FFE, 2'd0, 3'd0, 16'h0EFE}
  };

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 rsp_valid after reset", 32'(rsp_valid), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R11 no strobe when idle", 32'(rsp_valid), 0);
    xl(16'h0000, 2'd0);
    chk("R11 strobe", 32'(rsp_valid), 1);
    chk("R11 empty table gives range fault", 32'(rsp_fault), 1);

    cfg(4'd2, 5'd6);
    wr(4'd2, 1, 16'h1000, 13'h100, 3'b011);
    wr(4'd3, 0, 16'h2000, 13'h1000, 3'b111);
    wr(4'd4, 1, 16'h8000, 13'h800, 3'b100);
    wr(4'd7, 1, 16'hFF00, 13'hFFF, 3'b001);
    wr(4'd8, 1, 16'h4000, 13'h1000, 3'b111);

    // R1 R2 R3 R4 R5 R6 R7 vector walk
    for (int k = 0; k < NV; k++) begin
      xl(VEC[k][36:21], VEC[k][20:19]);
      chk($sformatf("R9 strobe vec%0d", k), 32'(rsp_valid), 1);
      chk($sformatf("R6 fault vec%0d", k), 32'(rsp_fault), 32'(VEC[k][18:16]));
      chk($sformatf("R7 paddr vec%0d", k), 32'(rsp_paddr), 32'(VEC[k][15:0]));
    end

    // R9: idle cycle has no strobe
    @(negedge clk);
    chk("R9 idle no strobe", 32'(rsp_valid), 0);

    // R10 same-cycle write uses old entry
    @(negedge clk);
    req_valid = 1; req_vaddr = 16'h0010; req_acc = 0;
    tw_en = 1; tw_idx = 4'd2; tw_valid = 1; tw_base = 16'h3000; tw_bound = 13'h100; tw_perm = 3'b011;
    @(negedge clk);
    req_valid = 0; tw_en = 0;
    chk("R10 same-cycle write not seen", 32'(rsp_paddr), 32'h1010);
    xl(16'h0010, 2'd0);
    chk("R10 next request sees write", 32'(rsp_paddr), 32'h3010);

    // R8 origin wrap: origin 14, segment 3 -> entry 1
    wr(4'd1, 1, 16'h6000, 13'h40, 3'b001);
    cfg(4'd14, 5'd16);
    xl(16'h3020, 2'd0);
    chk("R8 wrapped index fault", 32'(rsp_fault), 0);
    chk("R8 wrapped index paddr", 32'(rsp_paddr), 32'h6020);
    // R2 length 16 allows segment 15 -> entry 13 (invalid)
    xl(16'hF000, 2'd0);
    chk("R2 full length in range, R3 invalid", 32'(rsp_fault), 2);

    done = 1;
  end

  initial begin
    for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule